// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous SRAM with a small internal array and a four-word burst engine. Every control, address and data input is captured on the rising clock edge. A burst opens when one of two start strobes is sampled active while the device is selected. A 2-bit counter then produces the low address bits for the words that follow the supplied start address. The `order_xor` input picks the sequence. When it is high, the low bits are the start bits XOR the count. When it is low, they are the start bits plus the count, wrapping modulo four.

The host-side start strobe wins over the controller-side strobe and always opens a read. The controller-side strobe can open either a read or a write. Read data passes through one output register before it is visible. A combinational output enable gates the valid flag, which stands in for a tri-state bus. When the device is deselected, the output stays driven for one more cycle before it turns off. A doze input forces the deselected state. Memory contents survive it.

Top module: `burst_sram`

## Requirements
- R1: A read whose inputs are sampled at edge N presents its word on `rdata` with `rdata_vld` high after edge N+1, assuming `out_en_n` is low.
- R2: A start strobe opens an access only when `sel_n`=0, `sel_hi`=1 and `sel_lo_n`=0. Any other combination deselects the device, and a write issued with it leaves memory unchanged.
- R3: On a cycle that opens a burst with the host strobe, all write controls are ignored and the cycle is a read. A write on a later cycle of that burst does take effect.
- R4: The host strobe counts only when `sel_n`=0. When it is ignored, an open burst continues as if no strobe were present. When both strobes are active, the host strobe wins.
- R5: With `wr_all_n`=0, every byte lane is written. Otherwise byte lane i (bits 8i+7..8i) is written only when `wr_byte_n`=0 and `lane_wr_n[i]`=0. A cycle that writes no lane is a read.
- R6: With `order_xor`=1, the k-th word of a burst (k=0..3) uses low address bits equal to the start low bits XOR k.
- R7: With `order_xor`=0, the k-th word uses low address bits equal to the start low bits plus k, modulo 4.
- R8: Inside an open burst, `step_n`=0 advances the count and `step_n`=1 repeats the current address. The count wraps after the fourth word.
- R9: `out_en_n`=1 forces `rdata_vld` low within the same cycle, with no clock edge needed. Setting it back to 0 restores the valid flag and the held data.
- R10: After a deselect sampled at edge N, the previous read word stays valid after edge N+1. If the next cycle is also a deselect, the output is off after edge N+2.
- R11: While `doze`=1 is sampled, no read or write takes effect and the burst is closed. Stored words are kept, and the output turns off with the same two-cycle deselect rule.
- R12: After reset, `rdata_vld` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, used when a burst opens |
| wdata | input | BYTE_W*N_BYTES | Write data |
| sel_n | input | 1 | Primary select, active low |
| sel_hi | input | 1 | Extra select, active high |
| sel_lo_n | input | 1 | Extra select, active low |
| host_strt_n | input | 1 | Host-side burst start, active low, always a read |
| ctl_strt_n | input | 1 | Controller-side burst start, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Master enable for lane writes, active low |
| lane_wr_n | input | N_BYTES | Per-lane write enables, active low |
| out_en_n | input | 1 | Combinational output enable, active low |
| doze | input | 1 | Forced deselect, low power |
| order_xor | input | 1 | Burst order: 1 XOR, 0 linear |
| rdata | output | BYTE_W*N_BYTES | Read data, zero when not valid |
| rdata_vld | output | 1 | Output driven flag |

## Verification
The assertions check four rules on every cycle: a host-strobe start never decodes to a write, doze and deselecting selects always give an idle operation, the output register follows the two-step deselect rule, and the burst count holds when the device is not advancing. Some behaviour can only be shown by the bench's scenarios, because it depends on stored data and real address sequences. This covers the data that actually lands in memory, the XOR and linear address orders including the wrap after the fourth word, lane masking, and the preservation of contents through doze and deselected writes.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int N_BYTES = 2,
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  q_addr,
  input  logic               q_sel_n,
  input  logic               q_sel_hi,
  input  logic               q_sel_lo_n,
  input  logic               q_host_n,
  input  logic               q_ctl_n,
  input  logic               q_step_n,
  input  logic               q_wr_all_n,
  input  logic               q_wr_byte_n,
  input  logic [N_BYTES-1:0] q_lane_n,
  input  logic               q_doze,
  input  logic               q_order_xor,
  output op_e                op_o,
  output logic [ADDR_W-1:0]  acc_addr_o,
  output logic [N_BYTES-1:0] lane_we_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               act_q, act_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0]  base_q, base_d;

  logic               sel_all, host_go, ctl_go, any_go, start, desel;
  logic [N_BYTES-1:0] wr_mask;
  logic [BURST_W-1:0] cnt_use, lo_bits;
  op_e                op_d;

  // select and strobe decode
  always_comb begin
    sel_all = !q_sel_n && q_sel_hi && !q_sel_lo_n;
    host_go = !q_host_n && !q_sel_n;
    ctl_go  = !host_go && !q_ctl_n;
    any_go  = host_go || ctl_go;
    start   = any_go && sel_all && !q_doze;
    desel   = q_doze || (any_go && !sel_all) || (!any_go && !act_q);
  end

  // lane write mask
  always_comb begin
    if (!q_wr_all_n)      wr_mask = '1;
    else if (!q_wr_byte_n) wr_mask = ~q_lane_n;
    else                   wr_mask = '0;
  end

  // burst counter and address generation
  always_comb begin
    if (start)          cnt_use = '0;
    else if (!q_step_n) cnt_use = BURST_W'(cnt_q + 1'b1);
    else                cnt_use = cnt_q;
    base_d = start ? q_addr : base_q;
    if (q_order_xor) lo_bits = base_d[BURST_W-1:0] ^ cnt_use;
    else             lo_bits = BURST_W'(base_d[BURST_W-1:0] + cnt_use);
    acc_addr_o = {base_d[ADDR_W-1 -: HI_W], lo_bits};
  end

  // operation decode
  always_comb begin
    if (desel)                      op_d = OP_IDLE;
    else if (!host_go && |wr_mask)  op_d = OP_WR;
    else                            op_d = OP_RD;
    op_o      = op_d;
    lane_we_o = (op_d == OP_WR) ? wr_mask : '0;
    act_d     = start || (act_q && !desel);
    cnt_d     = desel ? cnt_q : cnt_use;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (start) base_q <= base_d;
  end

  // R8: an open burst with no strobe and no advance keeps its count
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && q_step_n && q_host_n && q_ctl_n && !q_doze) |=> (cnt_q == $past(cnt_q)))
    else $error("count moved while holding");
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 2
) (
  input  logic                      clk,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [N_BYTES-1:0]        lane_we_i,
  input  logic                      rd_en_i,
  input  logic [BYTE_W*N_BYTES-1:0] wdata_i,
  output logic [BYTE_W*N_BYTES-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    logic [BYTE_W-1:0] lane_rd;

    always_ff @(posedge clk) begin
      if (lane_we_i[g]) lane_mem[addr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_en_i) lane_rd <= lane_mem[addr_i];
    end

    assign rdata_o[g*BYTE_W +: BYTE_W] = lane_rd;
  end
endmodule

// File: rtl/burst_sram_outpipe.sv
module burst_sram_outpipe
  import burst_sram_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_i,
  input  logic              out_en_n,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_vld
);
  logic drive_q, drive_d;
  logic pend_q, pend_d;

  always_comb begin
    unique case (op_i)
      OP_RD:   begin drive_d = 1'b1;               pend_d = 1'b0; end
      OP_WR:   begin drive_d = 1'b0;               pend_d = 1'b0; end
      default: begin drive_d = drive_q && !pend_q; pend_d = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      drive_q <= drive_d;
      pend_q  <= pend_d;
    end
  end

  assign rdata_vld = drive_q && !out_en_n;
  assign rdata     = rdata_vld ? rd_word_i : '0;

  // R1: a decoded read drives the output after the next edge
  p_rd_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RD) |=> drive_q)
    else $error("read did not drive");

  // R10: first idle cycle keeps the output state
  p_dcd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_IDLE && !pend_q) |=> (drive_q == $past(drive_q)))
    else $error("output dropped after one deselect");

  // R10: second consecutive idle cycle turns the output off
  p_dcd_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_IDLE && pend_q) |=> !drive_q)
    else $error("output still on after two deselects");
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 2,
  parameter int BURST_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BYTE_W*N_BYTES-1:0] wdata,
  input  logic                      sel_n,
  input  logic                      sel_hi,
  input  logic                      sel_lo_n,
  input  logic                      host_strt_n,
  input  logic                      ctl_strt_n,
  input  logic                      step_n,
  input  logic                      wr_all_n,
  input  logic                      wr_byte_n,
  input  logic [N_BYTES-1:0]        lane_wr_n,
  input  logic                      out_en_n,
  input  logic                      doze,
  input  logic                      order_xor,
  output logic [BYTE_W*N_BYTES-1:0] rdata,
  output logic                      rdata_vld
);
  localparam int DATA_W = BYTE_W * N_BYTES;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  // input capture stage
  logic [ADDR_W-1:0]  q_addr;
  logic [DATA_W-1:0]  q_wdata;
  logic               q_sel_n, q_sel_hi, q_sel_lo_n, q_host_n, q_ctl_n, q_step_n;
  logic               q_wr_all_n, q_wr_byte_n, q_doze, q_order_xor;
  logic [N_BYTES-1:0] q_lane_n;

  always_ff @(posedge clk) begin
    q_addr  <= addr;
    q_wdata <= wdata;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      q_sel_n     <= 1'b1;
      q_sel_hi    <= 1'b0;
      q_sel_lo_n  <= 1'b1;
      q_host_n    <= 1'b1;
      q_ctl_n     <= 1'b1;
      q_step_n    <= 1'b1;
      q_wr_all_n  <= 1'b1;
      q_wr_byte_n <= 1'b1;
      q_lane_n    <= '1;
      q_doze      <= 1'b0;
      q_order_xor <= 1'b1;
    end else begin
      q_sel_n     <= sel_n;
      q_sel_hi    <= sel_hi;
      q_sel_lo_n  <= sel_lo_n;
      q_host_n    <= host_strt_n;
      q_ctl_n     <= ctl_strt_n;
      q_step_n    <= step_n;
      q_wr_all_n  <= wr_all_n;
      q_wr_byte_n <= wr_byte_n;
      q_lane_n    <= lane_wr_n;
      q_doze      <= doze;
      q_order_xor <= order_xor;
    end
  end

  op_e                op;
  logic [ADDR_W-1:0]  acc_addr;
  logic [N_BYTES-1:0] lane_we;
  logic [DATA_W-1:0]  rd_word;

  burst_sram_ctrl #(
    .ADDR_W (ADDR_W),
    .N_BYTES(N_BYTES),
    .BURST_W(BURST_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .q_addr     (q_addr),
    .q_sel_n    (q_sel_n),
    .q_sel_hi   (q_sel_hi),
    .q_sel_lo_n (q_sel_lo_n),
    .q_host_n   (q_host_n),
    .q_ctl_n    (q_ctl_n),
    .q_step_n   (q_step_n),
    .q_wr_all_n (q_wr_all_n),
    .q_wr_byte_n(q_wr_byte_n),
    .q_lane_n   (q_lane_n),
    .q_doze     (q_doze),
    .q_order_xor(q_order_xor),
    .op_o       (op),
    .acc_addr_o (acc_addr),
    .lane_we_o  (lane_we)
  );

  burst_sram_array #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .N_BYTES(N_BYTES)
  ) u_array (
    .clk      (clk),
    .addr_i   (acc_addr),
    .lane_we_i(lane_we),
    .rd_en_i  (op == OP_RD),
    .wdata_i  (q_wdata),
    .rdata_o  (rd_word)
  );

  burst_sram_outpipe #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .op_i     (op),
    .out_en_n (out_en_n),
    .rd_word_i(rd_word),
    .rdata    (rdata),
    .rdata_vld(rdata_vld)
  );

  // R3: a host-strobe start never becomes a write
  p_host_rd_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!q_host_n && !q_sel_n) |-> (op != OP_WR))
    else $error("host start decoded as write");

  // R11: doze forces an idle operation with no lane write
  p_doze_idle_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    q_doze |-> (op == OP_IDLE && lane_we == '0))
    else $error("access during doze");

  // R2: a controller start with an extra select off is a deselect
  p_desel_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (q_host_n && !q_ctl_n && (!q_sel_hi || q_sel_lo_n)) |-> (op == OP_IDLE))
    else $error("access while not selected");
endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic        sel_n, sel_hi, sel_lo_n, host_strt_n, ctl_strt_n, step_n;
  logic        wr_all_n, wr_byte_n, out_en_n, doze, order_xor;
  logic [1:0]  lane_wr_n;
  logic [15:0] rdata;
  logic        rdata_vld;

  always #5 clk = ~clk;

  burst_sram dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .host_strt_n(host_strt_n), .ctl_strt_n(ctl_strt_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
    .out_en_n(out_en_n), .doze(doze), .order_xor(order_xor),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  typedef struct {
    int          due;
    logic        vld;
    logic [15:0] data;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] tbm [64];
  int          cyc = 0;
  int          n_run = 0;
  int          n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares design output against queued expectations
  always @(negedge clk) begin
    #2;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      n_run++;
      if (sb[0].due != cyc || rdata_vld !== sb[0].vld ||
          (sb[0].vld && rdata !== sb[0].data)) begin
        n_fail++;
        $display("FAIL %s: actual vld=%b data=%h expected vld=%b data=%h",
                 sb[0].req, rdata_vld, rdata, sb[0].vld, sb[0].data);
      end
      void'(sb.pop_front());
    end
  end

  // driver: one clock of inputs; cen = {primary, extra high, extra low} enabled
  task automatic step(input bit host, input bit ctl, input bit adv,
                      input logic [5:0] a, input logic [15:0] d,
                      input bit gw, input bit bwe, input logic [1:0] lanes,
                      input logic [2:0] cen, input bit slp);
    @(negedge clk);
    host_strt_n = !host; ctl_strt_n = !ctl; step_n = !adv;
    addr = a; wdata = d;
    wr_all_n = !gw; wr_byte_n = !bwe; lane_wr_n = ~lanes;
    sel_n = !cen[2]; sel_hi = cen[1]; sel_lo_n = !cen[0];
    doze = slp;
  endtask

  function automatic void exp_rd(input int a, input string req);
    sb.push_back('{cyc + 2, 1'b1, tbm[a], req});
  endfunction

  function automatic void exp_val(input logic v, input logic [15:0] d, input string req);
    sb.push_back('{cyc + 2, v, d, req});
  endfunction

  function automatic void mw(input int a, input logic [15:0] d, input logic [1:0] m);
    if (m[0]) tbm[a][7:0]  = d[7:0];
    if (m[1]) tbm[a][15:8] = d[15:8];
  endfunction

  task automatic rd_start(input int a, input string req);
    step(0, 1, 0, 6'(a), 16'h0, 0, 0, 2'b00, 3'b111, 0);
    exp_rd(a, req);
  endtask

  task automatic rd_adv(input int a, input string req);
    step(0, 0, 1, 6'h0, 16'h0, 0, 0, 2'b00, 3'b111, 0);
    exp_rd(a, req);
  endtask

  task automatic wr_burst(input int base, input logic [15:0] seed);
    for (int k = 0; k < 4; k++) begin
      step(0, k == 0, k != 0, 6'(base), seed + 16'(k), 1, 0, 2'b00, 3'b111, 0);
      mw(base + k, seed + 16'(k), 2'b11);
    end
  endtask

  task automatic desel_cyc;
    step(0, 1, 0, 6'h0, 16'h0, 0, 0, 2'b00, 3'b011, 0);
  endtask

  task automatic set_order(input logic v);
    @(posedge clk); #1 order_xor = v;
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0;
    sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    host_strt_n = 1'b1; ctl_strt_n = 1'b1; step_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_wr_n = 2'b11;
    out_en_n = 1'b0; doze = 1'b0; order_xor = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 reset vld", 32'(rdata_vld), 32'd0);

    // preload in linear order
    wr_burst(8, 16'h1008);
    wr_burst(16, 16'h1610);
    wr_burst(32, 16'h2020);
    wr_burst(48, 16'h3030);

    // R1 R7 linear aligned, R8 wrap and hold
    rd_start(8, "R1 R7 lin k0");
    rd_adv(9, "R7 lin k1");
    rd_adv(10, "R7 lin k2");
    rd_adv(11, "R7 lin k3");
    rd_adv(8, "R8 wrap after four");
    step(0, 0, 0, 6'h0, 16'h0, 0, 0, 2'b00, 3'b111, 0); exp_rd(8, "R8 hold repeats");
    // R7 linear from offset 2
    rd_start(10, "R7 lin off2 k0");
    rd_adv(11, "R7 lin off2 k1");
    rd_adv(8, "R7 lin off2 k2");
    rd_adv(9, "R7 lin off2 k3");

    // R6 XOR order
    set_order(1'b1);
    rd_start(11, "R6 xor s3 k0");
    rd_adv(10, "R6 xor s3 k1");
    rd_adv(9, "R6 xor s3 k2");
    rd_adv(8, "R6 xor s3 k3");
    rd_start(9, "R6 xor s1 k0");
    rd_adv(8, "R6 xor s1 k1");
    rd_adv(11, "R6 xor s1 k2");
    rd_adv(10, "R6 xor s1 k3");
    set_order(1'b0);

    // R4 host strobe ignored without primary select; burst advances
    rd_start(8, "R4 setup");
    step(1, 0, 1, 6'h30, 16'h0, 0, 0, 2'b00, 3'b011, 0); exp_rd(9, "R4 host ignored");
    // R4 priority: host and controller together, controller write lost
    step(1, 1, 0, 6'h30, 16'hFFFF, 1, 0, 2'b00, 3'b111, 0); exp_rd(48, "R4 host wins");
    rd_start(48, "R4 no write by controller");

    // R3 host start ignores writes, later cycle writes
    step(1, 0, 0, 6'h20, 16'hDEAD, 1, 0, 2'b00, 3'b111, 0); exp_rd(32, "R3 host start reads");
    step(0, 0, 0, 6'h0, 16'hBEEF, 1, 0, 2'b00, 3'b111, 0); mw(32, 16'hBEEF, 2'b11);
    rd_start(32, "R3 follow-on write");

    // R5 lane writes
    step(0, 1, 0, 6'h10, 16'hAAAA, 0, 1, 2'b01, 3'b111, 0); mw(16, 16'hAAAA, 2'b01);
    step(0, 1, 0, 6'h11, 16'h5555, 1, 0, 2'b00, 3'b111, 0); mw(17, 16'h5555, 2'b11);
    step(0, 1, 0, 6'h12, 16'h7777, 0, 0, 2'b11, 3'b111, 0); exp_rd(18, "R5 no master no write");
    step(0, 1, 0, 6'h13, 16'h9999, 0, 1, 2'b10, 3'b111, 0); mw(19, 16'h9999, 2'b10);
    rd_start(16, "R5 lane0 only");
    rd_adv(17, "R5 all lanes");
    rd_adv(18, "R5 unchanged");
    rd_adv(19, "R5 lane1 only");

    // R2 deselecting combinations block writes
    step(0, 1, 0, 6'h30, 16'h0BAD, 1, 0, 2'b00, 3'b101, 0);
    step(0, 1, 0, 6'h31, 16'h0BAD, 1, 0, 2'b00, 3'b110, 0);
    step(0, 1, 0, 6'h32, 16'h0BAD, 1, 0, 2'b00, 3'b011, 0);
    rd_start(48, "R2 word0 kept");
    rd_adv(49, "R2 word1 kept");
    rd_adv(50, "R2 word2 kept");

    // R10 double-cycle deselect
    rd_start(33, "R10 read");
    desel_cyc(); exp_val(1'b1, tbm[33], "R10 still on after one");
    desel_cyc(); exp_val(1'b0, 16'h0, "R10 off after two");

    // R9 asynchronous output enable
    rd_start(34, "R9 read");
    step(0, 0, 0, 6'h0, 16'h0, 0, 0, 2'b00, 3'b111, 0); exp_rd(34, "R9 hold");
    repeat (3) @(negedge clk);
    #4 out_en_n = 1'b1;
    #1 check("R9 vld off", 32'(rdata_vld), 32'd0);
    check("R9 data zero", 32'(rdata), 32'd0);
    out_en_n = 1'b0;
    #1 check("R9 vld back", 32'(rdata_vld), 32'd1);
    check("R9 data back", 32'(rdata), 32'(tbm[34]));

    // R11 doze: no write, output turns off after two cycles
    step(0, 1, 0, 6'h23, 16'h0BAD, 1, 0, 2'b00, 3'b111, 1); exp_val(1'b1, tbm[34], "R11 first doze");
    step(0, 0, 1, 6'h0, 16'h0BAD, 1, 0, 2'b00, 3'b111, 1); exp_val(1'b0, 16'h0, "R11 off in doze");
    step(0, 0, 1, 6'h0, 16'h0, 0, 0, 2'b00, 3'b111, 0); exp_val(1'b0, 16'h0, "R11 burst closed");
    rd_start(35, "R11 contents kept");

    repeat (4) @(negedge clk);
    check("queue drained", 32'(sb.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule